// File: doc/BRIEF.md
# Bus-Programmed Watchdog Timer

A watchdog timer for a system that must recover by itself when software stops making progress. Software programs a 16-bit timeout in ticks, sets the run bit and then writes a reload strobe at intervals shorter than that timeout. If the strobes stop and the down-counter runs out while the timer runs, the block latches a fired status and issues a one-clock request. The request goes on either a reset line or a shutdown line, chosen by a control bit. A tick prescaler divides the system clock by a parameter, so one tick can be a second in the chip and a few clocks in a testbench.

Two registers sit on a simple valid/write/address/data bus: a control/status word at byte offset 0 and a count word at byte offset 4. An external hardware-disable input holds the timer stopped and is visible in the control word. A cause flag records that the last system reset came from this watchdog. It survives the ordinary block reset `rst_n` and is cleared only by the power-on reset `por_n`, so software can read it after the reboot the watchdog caused.

Top module: `wdog_timer`

## Requirements
- R1: The control word is decoded at byte address 0 and the count word at byte address 4, and only an exact match selects either one. Reads of any other address return 0, and writes to any other address change nothing.
- R2: Control bit 0 (run) enables counting. Clearing it freezes the live count, and setting it again without a reload resumes from the frozen value with a freshly started tick.
- R3: Writing control bit 7 as 1 loads the live count from the programmed timeout and restarts the prescaler. Expiry follows N×DIV clocks after that write, with N the timeout and DIV the prescaler ratio. Control bits 7:4 always read 0.
- R4: Count-word bits 15:0 hold the programmed timeout and bits 31:16 read the live count. Writing the count word changes only the timeout and leaves the live count untouched until the next reload.
- R5: On expiry the block sets control bit 1 (fired), clears run and raises the selected request for exactly one clock. Counting then stays stopped while fired is set, even if run is written to 1.
- R6: Control bit 2 selects the expiry action: 1 drives `shdn_req`, 0 drives `rst_req`. The two requests are never high together.
- R7: Fired is cleared by writing 1 to bit 1 and is not affected by writing 0 to that bit. A control write of 0x2 clears fired and leaves run at 0.
- R8: Control bit 3 reads the `hw_disable` input and ignores writes. While `hw_disable` is high, run is forced to 0 and neither request can occur.
- R9: Control bit 8 is a read-only flag that is set by a reset-action expiry. A shutdown expiry does not set it. It keeps its value through `rst_n`, and only `por_n` clears it.
- R10: After reset the control word reads 0, the count word reads 0xFFFFFFFF (timeout and live count both 0xFFFF), and both requests are low.
- R11: A reload with a timeout of 0 expires at the first tick, DIV clocks after the reload write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Synchronous active-low block reset; leaves the cause flag untouched |
| por_n | input | 1 | Synchronous active-low power-on reset; clears the cause flag |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during a read |
| hw_disable | input | 1 | Hardware hold-off; while high the timer cannot run |
| rst_req | output | 1 | One-clock reset request on a reset-action expiry |
| shdn_req | output | 1 | One-clock shutdown request on a shutdown-action expiry |

## Verification
The checker watches several rules on every clock. It checks that each request lasts one clock and that the two requests are exclusive. It checks that any request coincides with fired being set, and that `hw_disable` forces run low and blocks requests. It checks that the cause flag holds until a power-on reset, that the reserved and reload bits read 0, and that the live count rises only after a reload write. The exact expiry latency of N×DIV clocks, and the freeze-and-resume behaviour of the run bit, can only be shown by the bench's scenarios. The same holds for the write-1-to-clear rule, for a reload that postpones expiry, and for the flag surviving a block reset.

// File: rtl/wdog_pkg.sv
// Package wdog_pkg
// Shared register offsets, control-bit positions and read-word builders for
// the watchdog timer. Assumes 32-bit registers and a byte-addressed bus.
package wdog_pkg;

    localparam int REG_W        = 32;
    localparam int OFS_CTRL     = 0;
    localparam int OFS_COUNT    = 4;

    // Control word bit positions
    localparam int CB_RUN       = 0;
    localparam int CB_FIRED     = 1;
    localparam int CB_ACTION    = 2;
    localparam int CB_HWDIS     = 3;
    localparam int CB_RELOAD    = 7;
    localparam int CB_CAUSE     = 8;

    // Count word: live count sits in the upper half
    localparam int LIVE_SHIFT   = 16;

    // Assemble the control word seen by a read
    function automatic logic [REG_W-1:0] pack_ctrl(
        input logic run,
        input logic fired,
        input logic action,
        input logic hwdis,
        input logic cause
    );
        logic [REG_W-1:0] w;
        w             = '0;
        w[CB_RUN]     = run;
        w[CB_FIRED]   = fired;
        w[CB_ACTION]  = action;
        w[CB_HWDIS]   = hwdis;
        w[CB_CAUSE]   = cause;
        return w;
    endfunction

    // Assemble the count word: timeout low, live count high
    function automatic logic [REG_W-1:0] pack_count(
        input logic [15:0] timeout,
        input logic [15:0] live
    );
        return {live, timeout};
    endfunction

endpackage

// File: rtl/wdog_prescaler.sv
// Module wdog_prescaler
// Divides the system clock into a one-clock tick every DIV cycles while
// enabled. A clear input restarts the division so the first tick after a
// clear comes exactly DIV cycles later. Assumes DIV >= 1.
module wdog_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_direct
            logic unused_in;
            assign unused_in = clk ^ rst_n ^ clr;
            // Every enabled cycle is a tick
            assign tick = en;
        end else begin : g_div
            logic [PRE_W-1:0] pre_q;
            logic             wrap;

            assign wrap = (pre_q == PRE_W'(DIV - 1));
            assign tick = en & wrap & ~clr;

            // Phase counter: restarts on clear, advances while enabled
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else if (clr || !en) begin
                    pre_q <= '0;
                end else if (wrap) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wdog_downcnt.sv
// Module wdog_downcnt
// Live timeout counter. Loads on request, decrements by one per step and
// saturates at zero. Reports when the next step ends the count (value 0 or 1).
module wdog_downcnt #(
    parameter int               W       = 16,
    parameter logic [W-1:0]     RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic         last
);
    logic [W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign last = (cnt_q <= W'(1));

    // Count register: load wins over a decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/wdog_regdec.sv
// Module wdog_regdec
// Decodes the register bus into per-register write strobes and muxes the
// read data. Only exact byte addresses select a register; everything else
// reads 0 and ignores writes. Read data is combinational.
module wdog_regdec
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  ctrl_word,
    input  logic [REG_W-1:0]  count_word,
    output logic              ctrl_we,
    output logic              count_we,
    output logic [REG_W-1:0]  rdata
);
    logic hit_ctrl;
    logic hit_count;

    assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_count = (bus_addr == ADDR_W'(OFS_COUNT));

    assign ctrl_we   = bus_valid & bus_write & hit_ctrl;
    assign count_we  = bus_valid & bus_write & hit_count;

    // Read mux: selected register or zero
    always_comb begin
        rdata = '0;
        if (bus_valid && !bus_write) begin
            if (hit_ctrl) begin
                rdata = ctrl_word;
            end else if (hit_count) begin
                rdata = count_word;
            end
        end
    end

endmodule

// File: rtl/wdog_timer.sv
// Module wdog_timer (top)
// Watchdog timer with a control/status word and a count word. Holds the run,
// fired and action state, the programmed timeout and the sticky reset-cause
// flag (kept across rst_n, cleared by por_n). Assumes CNT_W <= 16 so that the
// timeout and live count share one 32-bit count word.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TICK_DIV = 250_000_000,
    parameter int ADDR_W   = 4,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              hw_disable,
    output logic              rst_req,
    output logic              shdn_req
);
    localparam logic [CNT_W-1:0] CNT_RST = '1;

    logic             ctrl_we;
    logic             count_we;
    logic             run_q;
    logic             fired_q;
    logic             action_q;
    logic             cause_q;
    logic             rst_req_q;
    logic             shdn_req_q;
    logic [CNT_W-1:0] timeout_q;
    logic [CNT_W-1:0] live_cnt;
    logic             live_last;
    logic             active;
    logic             reload;
    logic             tick;
    logic             expire;
    logic [31:0]      ctrl_word;
    logic [31:0]      count_word;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    assign active = run_q & ~fired_q & ~hw_disable;
    assign reload = ctrl_we & bus_wdata[CB_RELOAD];
    assign expire = active & tick & live_last & ~reload;

    assign ctrl_word  = pack_ctrl(run_q, fired_q, action_q, hw_disable, cause_q);
    assign count_word = pack_count(16'(timeout_q), 16'(live_cnt));

    wdog_regdec #(
        .ADDR_W (ADDR_W)
    ) u_dec (
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .ctrl_word  (ctrl_word),
        .count_word (count_word),
        .ctrl_we    (ctrl_we),
        .count_we   (count_we),
        .rdata      (bus_rdata)
    );

    wdog_prescaler #(
        .DIV (TICK_DIV)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (reload),
        .en    (active),
        .tick  (tick)
    );

    wdog_downcnt #(
        .W       (CNT_W),
        .RST_VAL (CNT_RST)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (reload),
        .load_val (timeout_q),
        .step     (active & tick),
        .cnt      (live_cnt),
        .last     (live_last)
    );

    // Run bit: hardware disable and expiry force it low, else follows writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (hw_disable || expire) begin
            run_q <= 1'b0;
        end else if (ctrl_we) begin
            run_q <= bus_wdata[CB_RUN];
        end
    end

    // Fired status: set by expiry, cleared by writing 1 to its bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
        end else if (expire) begin
            fired_q <= 1'b1;
        end else if (ctrl_we && bus_wdata[CB_FIRED]) begin
            fired_q <= 1'b0;
        end
    end

    // Action select: plain read/write bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            action_q <= 1'b0;
        end else if (ctrl_we) begin
            action_q <= bus_wdata[CB_ACTION];
        end
    end

    // Programmed timeout: written through the count word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= CNT_RST;
        end else if (count_we) begin
            timeout_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Expiry requests: one-clock pulse on the selected line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q  <= 1'b0;
            shdn_req_q <= 1'b0;
        end else begin
            rst_req_q  <= expire & ~action_q;
            shdn_req_q <= expire &  action_q;
        end
    end

    // Reset-cause flag: only power-on reset clears it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if (expire && !action_q) begin
            cause_q <= 1'b1;
        end
    end

    assign rst_req  = rst_req_q;
    assign shdn_req = shdn_req_q;

endmodule

// File: rtl/wdog_timer_chk.sv
// Module wdog_timer_chk
// Property checker for wdog_timer, attached by bind. Observes ports and a few
// internal state bits; drives nothing.
module wdog_timer_chk #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              hw_disable,
    input logic              rst_req,
    input logic              shdn_req,
    input logic              run_q,
    input logic              fired_q,
    input logic              cause_q,
    input logic [CNT_W-1:0]  live_cnt
);
    logic reload_wr;
    logic ctrl_rd;

    assign reload_wr = bus_valid & bus_write & (bus_addr == '0) & bus_wdata[7];
    assign ctrl_rd   = bus_valid & ~bus_write & (bus_addr == '0);

    AST_RST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);                                              // R5
    AST_SHDN_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> !shdn_req);                                            // R5
    AST_REQ_WITH_FIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || shdn_req) |-> fired_q);                                 // R5
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && shdn_req));                                            // R6
    AST_HWDIS_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hw_disable |=> !run_q);                                             // R8
    AST_HWDIS_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hw_disable |=> !(rst_req || shdn_req));                             // R8
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        cause_q |=> cause_q);                                               // R9
    AST_CTRL_HIGH_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd |-> (bus_rdata[7:4] == 4'h0));                              // R3
    AST_LIVE_RISES_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cnt > $past(live_cnt)) |-> $past(reload_wr));                 // R4

endmodule

bind wdog_timer wdog_timer_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .hw_disable (hw_disable),
    .rst_req    (rst_req),
    .shdn_req   (shdn_req),
    .run_q      (run_q),
    .fired_q    (fired_q),
    .cause_q    (cause_q),
    .live_cnt   (live_cnt)
);

// File: tb/tb_wdog_timer.sv
// Bench for wdog_timer: a table of register accesses walked by one loop,
// then directed scenarios for expiry timing, actions, status and resets.
module tb_wdog_timer;
    localparam int DIV    = 4;
    localparam int ADDR_W = 4;
    localparam int NVEC   = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              por_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              hw_disable = 1'b0;
    logic              rst_req;
    logic              shdn_req;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    wdog_timer #(
        .TICK_DIV (DIV),
        .ADDR_W   (ADDR_W),
        .CNT_W    (16)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_n      (por_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .hw_disable (hw_disable),
        .rst_req    (rst_req),
        .shdn_req   (shdn_req)
    );

    // Vector: {write, addr[3:0], wdata[31:0], expected read[31:0]}
    localparam logic [68:0] VEC [NVEC] = '{
        {1'b1, 4'h0, 32'h0000_0004, 32'h0},          // set action
        {1'b0, 4'h0, 32'h0,         32'h0000_0004},
        {1'b1, 4'h0, 32'h0000_00F4, 32'h0},          // reserved + reload bits
        {1'b0, 4'h0, 32'h0,         32'h0000_0004},
        {1'b1, 4'h4, 32'h1234_ABCD, 32'h0},          // timeout write
        {1'b0, 4'h4, 32'h0,         32'hFFFF_ABCD},  // live untouched
        {1'b1, 4'h0, 32'h0000_0084, 32'h0},          // reload
        {1'b0, 4'h4, 32'h0,         32'hABCD_ABCD},
        {1'b1, 4'h8, 32'hFFFF_FFFF, 32'h0},          // unmapped write
        {1'b0, 4'h8, 32'h0,         32'h0},
        {1'b1, 4'h1, 32'h0000_0003, 32'h0},          // unaligned write
        {1'b0, 4'h0, 32'h0,         32'h0000_0004},
        {1'b1, 4'h0, 32'h0000_0008, 32'h0},          // try to set hw bit
        {1'b0, 4'h0, 32'h0,         32'h0},
        {1'b0, 4'hC, 32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Cycles from the last write edge to the first request, its line and width
    task automatic measure(input int limit, output int cyc, output logic shdn, output int width);
        cyc = -1; shdn = 1'b0; width = 0;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (rst_req || shdn_req) begin
                cyc = k; shdn = shdn_req; width = 1;
                break;
            end
        end
        if (cyc > 0) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                if (rst_req || shdn_req) width++;
            end
        end
    endtask

    // Watchdog: a hung run is a failure but still reports
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: bench did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          cyc;
        int          width;
        logic        shdn;

        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;

        // R10: reset state
        bus_rd(4'h0, rd); check("R10 ctrl after reset", rd, 32'h0);
        bus_rd(4'h4, rd); check("R10 count after reset", rd, 32'hFFFF_FFFF);
        check("R10 requests low", {30'b0, rst_req, shdn_req}, 32'h0);

        // R1/R3/R4/R8: table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][68]) begin
                bus_wr(VEC[i][67:64], VEC[i][63:32]);
            end else begin
                bus_rd(VEC[i][67:64], rd);
                check($sformatf("R1/R3/R4/R8 table step %0d", i), rd, VEC[i][31:0]);
            end
        end

        // R6: shutdown action, timeout 1
        bus_wr(4'h4, 32'h1);
        bus_wr(4'h0, 32'h85);
        measure(40, cyc, shdn, width);
        check("R6 shutdown latency", 32'(cyc), 32'(DIV));
        check("R6 shutdown line", {31'b0, shdn}, 32'h1);
        check("R5 shutdown width", 32'(width), 32'h1);
        bus_rd(4'h0, rd); check("R9 shutdown leaves cause clear", rd, 32'h0000_0006);
        bus_wr(4'h0, 32'h2);

        // R8: hardware disable blocks running
        @(negedge clk); hw_disable = 1'b1;
        bus_wr(4'h4, 32'h1);
        bus_wr(4'h0, 32'h81);
        bus_rd(4'h0, rd); check("R8 run forced low, bit3 set", rd, 32'h0000_0008);
        measure(20, cyc, shdn, width);
        check("R8 no request while disabled", 32'(cyc), 32'hFFFF_FFFF);
        @(negedge clk); hw_disable = 1'b0;
        bus_rd(4'h0, rd); check("R8 released, run still 0", rd, 32'h0);

        // R3/R5: reset action, timeout 3
        bus_wr(4'h4, 32'h3);
        bus_wr(4'h0, 32'h81);
        measure(80, cyc, shdn, width);
        check("R3 expiry latency N*DIV", 32'(cyc), 32'(3 * DIV));
        check("R6 reset line", {31'b0, shdn}, 32'h0);
        check("R5 reset width", 32'(width), 32'h1);
        bus_rd(4'h0, rd); check("R5 fired set, run cleared, R9 cause", rd, 32'h0000_0102);
        bus_rd(4'h4, rd); check("R5 live count at zero", rd, 32'h0000_0003);

        // R5: run rewritten while fired stays stopped
        bus_wr(4'h0, 32'h1);
        measure(20, cyc, shdn, width);
        check("R5 no count while fired", 32'(cyc), 32'hFFFF_FFFF);
        // R7: write 0 to fired keeps it, write 1 clears it
        bus_wr(4'h0, 32'h1);
        bus_rd(4'h0, rd); check("R7 zero write keeps fired", rd, 32'h0000_0103);
        bus_wr(4'h0, 32'h2);
        bus_rd(4'h0, rd); check("R7 clear write", rd, 32'h0000_0100);

        // R2: stop freezes, restart resumes from held value
        bus_wr(4'h4, 32'h2);
        bus_wr(4'h0, 32'h81);
        repeat (2) @(negedge clk);
        bus_wr(4'h0, 32'h0);
        measure(20, cyc, shdn, width);
        check("R2 stopped, no request", 32'(cyc), 32'hFFFF_FFFF);
        bus_rd(4'h4, rd); check("R2 frozen live count", rd, 32'h0001_0002);
        bus_wr(4'h0, 32'h1);
        measure(40, cyc, shdn, width);
        check("R2 resume latency", 32'(cyc), 32'(DIV));
        bus_wr(4'h0, 32'h2);

        // R3: reload postpones expiry
        bus_wr(4'h4, 32'h2);
        bus_wr(4'h0, 32'h81);
        repeat (5) @(negedge clk);
        bus_wr(4'h0, 32'h81);
        measure(40, cyc, shdn, width);
        check("R3 reload restarts full timeout", 32'(cyc), 32'(2 * DIV));
        bus_wr(4'h0, 32'h2);

        // R11: zero timeout expires at first tick
        bus_wr(4'h4, 32'h0);
        bus_wr(4'h0, 32'h81);
        measure(40, cyc, shdn, width);
        check("R11 zero timeout latency", 32'(cyc), 32'(DIV));

        // R9: cause survives block reset, cleared by power-on reset
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        bus_rd(4'h0, rd); check("R9 cause kept over rst_n", rd, 32'h0000_0100);
        bus_rd(4'h4, rd); check("R10 count after rst_n", rd, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b0; por_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1; por_n = 1'b1;
        bus_rd(4'h0, rd); check("R9 cause cleared by por_n", rd, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule